// File: doc/BRIEF.md
# Subtract-and-Branch Sequencer

This block is a small multicycle processor whose entire instruction set is a single operation. Each instruction is three consecutive memory words: a source address, a destination address and a jump target. The machine subtracts the source word from the destination word and writes the difference back to the destination. If that difference is zero or negative it jumps to the target. Otherwise it moves on to the next three-word instruction.

Program and data share one internal word memory. A host loads that memory through a write port while the machine is held stopped, then raises `run`. Execution always starts at address 0. Each instruction takes a fixed six steps:

1. Fetch the source address word.
2. Fetch the destination address word.
3. Fetch the target word.
4. Read the source operand.
5. Read the destination operand and form the difference.
6. Store the difference and choose the next program counter.

A taken branch whose target word is negative stops the machine. A read-back port shows any memory word at any time, which lets the host collect results.

Top module: `sbn_core`

## Requirements
- R1: After a synchronous reset, `pc` is 0 and `halted` is 0.
- R2: While `run` is low, a cycle with `host_we` high stores `host_wdata` at `host_addr`. In every cycle, `rb_data` shows the word that was at `rb_addr` at the previous clock edge.
- R3: While `run` is high, `host_we` has no effect on the memory.
- R4: An instruction at `pc` takes its source address from the low 8 bits of word `pc` and its destination address from the low 8 bits of word `pc+1`. It then stores (Mem[dst] - Mem[src]) modulo 2^16 into Mem[dst].
- R5: If the stored difference, read as signed 16-bit, is zero or negative, and bit 15 of the target word (word `pc+2`) is 0, then the next `pc` is the low 8 bits of the target word.
- R6: If the stored difference is positive, the next `pc` is `pc+3` modulo 256.
- R7: If the difference is zero or negative and bit 15 of the target word is 1, the store still happens. `halted` then rises and `pc` stays at the address of that instruction for as long as `run` stays high.
- R8: Every instruction takes exactly six clock cycles. Once `run` is seen high at a clock edge, the first instruction's new `pc` appears at the 7th clock edge counted from, and including, that edge. Each later instruction's `pc` appears six edges after the previous one.
- R9: At the first clock edge with `run` low, `pc` returns to 0 and `halted` clears. Raising `run` again restarts execution from address 0.
- R10: Address and word arithmetic wraps modulo 256 for `pc`, and only the low 8 bits of the source and destination words are used as addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to execute, low to stop and hold at address 0 |
| host_we | input | 1 | Host write strobe, honoured only while run is low |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 16 | Host write data |
| rb_addr | input | 8 | Read-back address |
| rb_data | output | 16 | Registered read-back word |
| pc | output | 8 | Program counter |
| halted | output | 1 | High once a stop branch has been taken |

## Verification
The assertions assume two things: `rst` is high from time zero for at least one edge, and the host loads every memory word before `run` is first raised, so no operand is ever unknown. They also assume `host_we` is low at the edge where `run` falls, so that no host write lands in the cycle the machine stops. The stimulus meets these conditions. It writes the full memory before every run, issues random host writes only while `run` is high (where they must be ignored), and clears the strobe before lowering `run`.

// File: rtl/sbn_pkg.sv
package sbn_pkg;

    localparam int WORD_W_DEF = 16;
    localparam int ADDR_W_DEF = 8;
    // cycles spent on one instruction: three fetches, two operand reads, one store
    localparam int STEPS      = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FSRC,
        ST_FDST,
        ST_FTGT,
        ST_RSRC,
        ST_RDST,
        ST_STORE,
        ST_STOP
    } state_e;

endpackage

// File: rtl/sbn_mem.sv
module sbn_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] core_addr,
    output logic [DW-1:0] core_rdata,
    input  logic          core_we,
    input  logic [DW-1:0] core_wdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    assign core_rdata = store[core_addr];

    always_ff @(posedge clk) begin
        if (core_we) begin
            store[core_addr] <= core_wdata;
        end else if (host_we) begin
            store[host_addr] <= host_wdata;
        end
        rb_data <= store[rb_addr];
    end

endmodule

// File: rtl/sbn_alu.sv
module sbn_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] minuend,
    input  logic [DW-1:0] subtrahend,
    output logic [DW-1:0] diff_next,
    input  logic [DW-1:0] diff_q,
    input  logic [DW-1:0] target_q,
    output logic          take,
    output logic          stop
);
    always_comb begin
        diff_next = minuend - subtrahend;
        take      = diff_q[DW-1] || (diff_q == '0);
        stop      = take && target_q[DW-1];
    end

endmodule

// File: rtl/sbn_ctrl.sv
module sbn_ctrl
    import sbn_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] diff_next,
    input  logic          take,
    input  logic          stop,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] src_val_q,
    output logic [DW-1:0] diff_q,
    output logic [DW-1:0] target_q,
    output logic [AW-1:0] pc,
    output logic          halted,
    output state_e        state
);
    localparam logic [AW-1:0] ONE   = AW'(1);
    localparam logic [AW-1:0] TWO   = AW'(2);
    localparam logic [AW-1:0] THREE = AW'(3);

    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;

    always_comb begin
        unique case (state)
            ST_FSRC:  mem_addr = pc;
            ST_FDST:  mem_addr = pc + ONE;
            ST_FTGT:  mem_addr = pc + TWO;
            ST_RSRC:  mem_addr = src_q;
            ST_RDST:  mem_addr = dst_q;
            ST_STORE: mem_addr = dst_q;
            default:  mem_addr = pc;
        endcase
    end

    assign mem_we    = run && (state == ST_STORE);
    assign mem_wdata = diff_q;
    assign halted    = (state == ST_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pc        <= '0;
            src_q     <= '0;
            dst_q     <= '0;
            target_q  <= '0;
            src_val_q <= '0;
            diff_q    <= '0;
        end else if (!run) begin
            state <= ST_IDLE;
            pc    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: state <= ST_FSRC;
                ST_FSRC: begin
                    src_q <= mem_rdata[AW-1:0];
                    state <= ST_FDST;
                end
                ST_FDST: begin
                    dst_q <= mem_rdata[AW-1:0];
                    state <= ST_FTGT;
                end
                ST_FTGT: begin
                    target_q <= mem_rdata;
                    state    <= ST_RSRC;
                end
                ST_RSRC: begin
                    src_val_q <= mem_rdata;
                    state     <= ST_RDST;
                end
                ST_RDST: begin
                    diff_q <= diff_next;
                    state  <= ST_STORE;
                end
                ST_STORE: begin
                    if (stop) begin
                        state <= ST_STOP;
                    end else begin
                        pc    <= take ? target_q[AW-1:0] : pc + THREE;
                        state <= ST_FSRC;
                    end
                end
                default: state <= ST_STOP;
            endcase
        end
    end

endmodule

// File: rtl/sbn_core.sv
module sbn_core
    import sbn_pkg::*;
#(
    parameter int DW = WORD_W_DEF,
    parameter int AW = ADDR_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    output logic [AW-1:0] pc,
    output logic          halted
);
    logic [AW-1:0] core_addr;
    logic [DW-1:0] core_rdata;
    logic          core_we;
    logic [DW-1:0] core_wdata;
    logic [DW-1:0] src_val_q;
    logic [DW-1:0] diff_q;
    logic [DW-1:0] target_q;
    logic [DW-1:0] diff_next;
    logic          take;
    logic          stop;
    logic          host_ok;
    state_e        state;

    assign host_ok = host_we && !run;

    sbn_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk        (clk),
        .core_addr  (core_addr),
        .core_rdata (core_rdata),
        .core_we    (core_we),
        .core_wdata (core_wdata),
        .host_we    (host_ok),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rb_addr    (rb_addr),
        .rb_data    (rb_data)
    );

    sbn_alu #(.DW(DW)) u_alu (
        .minuend    (core_rdata),
        .subtrahend (src_val_q),
        .diff_next  (diff_next),
        .diff_q     (diff_q),
        .target_q   (target_q),
        .take       (take),
        .stop       (stop)
    );

    sbn_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .mem_rdata (core_rdata),
        .diff_next (diff_next),
        .take      (take),
        .stop      (stop),
        .mem_addr  (core_addr),
        .mem_we    (core_we),
        .mem_wdata (core_wdata),
        .src_val_q (src_val_q),
        .diff_q    (diff_q),
        .target_q  (target_q),
        .pc        (pc),
        .halted    (halted),
        .state     (state)
    );

endmodule

// File: rtl/sbn_core_chk.sv
module sbn_core_chk
    import sbn_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          run,
    input logic [AW-1:0] pc,
    input logic          halted,
    input state_e        state
);
    localparam logic [2:0] LAST = 3'(STEPS - 1);

    logic [2:0] step_cnt;

    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE || state == ST_STORE) begin
            step_cnt <= '0;
        end else begin
            step_cnt <= step_cnt + 3'd1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && !halted));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pc == '0 && !halted));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && run) |=> (halted && $stable(pc)));

    // R8
    step_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STORE) |-> (step_cnt == LAST));

    // R8
    pc_move_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && pc != $past(pc)) |-> ($past(state) == ST_STORE));

endmodule

bind sbn_core sbn_core_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .pc     (pc),
    .halted (halted),
    .state  (state)
);

// File: tb/sbn_core_bench.sv
module sbn_core_bench;

    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [AW-1:0] rb_addr = '0;
    logic [DW-1:0] rb_data;
    logic [AW-1:0] pc;
    logic          halted;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] mdl [DEPTH];
    logic [AW-1:0] mpc;
    logic          mhalt;

    always #2 clk = ~clk;

    sbn_core u_sbn_core (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rb_addr    (rb_addr),
        .rb_data    (rb_data),
        .pc         (pc),
        .halted     (halted)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        mdl[a]     = d;
    endtask

    task automatic put_done();
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic model_step();
        logic [AW-1:0] sa;
        logic [AW-1:0] da;
        logic [DW-1:0] tw;
        logic [DW-1:0] d;
        if (!mhalt) begin
            sa = mdl[mpc][AW-1:0];
            da = mdl[mpc + 8'd1][AW-1:0];
            tw = mdl[mpc + 8'd2];
            d  = mdl[da] - mdl[sa];
            mdl[da] = d;
            if (d[DW-1] || d == '0) begin
                if (tw[DW-1]) mhalt = 1'b1;
                else          mpc = tw[AW-1:0];
            end else begin
                mpc = mpc + 8'd3;
            end
        end
    endtask

    task automatic readback_all(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            rb_addr = AW'(i);
            @(negedge clk);
            chk(req, rb_data, mdl[i]);
        end
    endtask

    // run n instructions from address 0, optionally poking host writes meanwhile
    task automatic run_for(input int n, input bit poke, input string req);
        run  = 1'b1;
        mpc  = '0;
        mhalt = 1'b0;
        for (int i = 0; i < 1 + 6 * n; i++) begin
            if (poke) begin
                host_we    = ($urandom % 4) == 0;
                host_addr  = AW'($urandom);
                host_wdata = DW'($urandom);
            end
            @(negedge clk);
        end
        host_we = 1'b0;
        for (int i = 0; i < n; i++) model_step();
        chk({req, " pc"}, pc, mpc);
        chk({req, " halted"}, halted, mhalt);
        run = 1'b0;
        @(negedge clk);
        // R9: stopping returns to address 0 and clears halted
        chk("R9 pc after stop", pc, 0);
        chk("R9 halted after stop", halted, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pc after reset", pc, 0);
        chk("R1 halted after reset", halted, 0);

        // directed program
        for (int i = 0; i < DEPTH; i++) put(AW'(i), '0);
        put(8'd0, 16'd10);  put(8'd1, 16'd11);  put(8'd2, 16'd3);
        put(8'd3, 16'd12);  put(8'd4, 16'd13);  put(8'd5, 16'd20);
        put(8'd20, 16'd14); put(8'd21, 16'd15); put(8'd22, 16'd5);
        put(8'd23, 16'd16); put(8'd24, 16'd17); put(8'd25, 16'hFFFF);
        put(8'd10, 16'd1);  put(8'd11, 16'd5);
        put(8'd12, 16'd5);  put(8'd13, 16'd5);
        put(8'd14, 16'd1);  put(8'd15, 16'h8000);
        put(8'd16, 16'd1);  put(8'd17, 16'd0);
        put_done();
        readback_all("R2 host load");

        run = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 pc held during first instruction", pc, 0);
        @(negedge clk);
        chk("R6 R8 positive result steps by three", pc, 3);
        repeat (6) @(negedge clk);
        chk("R5 zero result branches", pc, 20);
        repeat (6) @(negedge clk);
        chk("R6 wrapped positive result falls through", pc, 23);
        chk("R7 not halted yet", halted, 0);
        // R3: a host write while running must not land
        host_we = 1'b1; host_addr = 8'd40; host_wdata = 16'h1234;
        @(negedge clk);
        host_we = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 stop branch halts", halted, 1);
        chk("R7 pc frozen at halting instruction", pc, 23);
        repeat (10) @(negedge clk);
        chk("R7 halted held", halted, 1);
        chk("R7 pc held", pc, 23);
        run = 1'b0;
        @(negedge clk);
        chk("R9 pc cleared", pc, 0);
        chk("R9 halted cleared", halted, 0);
        mpc = '0;
        mhalt = 1'b0;
        for (int i = 0; i < 4; i++) model_step();
        chk("R4 model sanity", mdl[11], 4);
        rb_addr = 8'd40;
        @(negedge clk);
        chk("R3 host write ignored while running", rb_data, 0);
        rb_addr = 8'd17;
        @(negedge clk);
        chk("R7 store done on halting instruction", rb_data, 16'hFFFF);
        readback_all("R4 directed memory");

        // R9 restart from address 0 on the updated memory
        run_for(4, 1'b0, "R9 restart");
        readback_all("R9 R4 restart memory");

        // random programs with full-width address words (R10)
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (($urandom % 3) == 0) put(AW'(i), DW'($urandom % 8) - 16'd3);
                else                     put(AW'(i), DW'($urandom));
            end
            put_done();
            run_for(40, 1'b1, "R5 R6 R7 R10 random run");
            readback_all("R3 R4 R10 random memory");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule